// File: doc/BRIEF.md
# Early-Late PN Code Tracker

This block takes over from a coarse acquisition search and keeps a locally generated pseudo-noise chip sequence in fine alignment with a received chip stream. The stream arrives at four samples per chip, one hard-decision sample for each strobe. The block holds a punctual timing estimate in samples. From it, it derives two extra replicas, one two samples (half a chip) ahead and one two samples behind. Each replica is compared with every received sample, and the agreement difference is summed over a 64-chip window. At the end of the window a three-way decision moves the punctual timing one sample later or earlier, or leaves it alone.

Acquisition hands over by raising the enable with the coarse code phase on the initial-offset input. The first enable after reset loads that phase. A short seek then fast-forwards the code generator to the matching chip, and tracking begins. Dropping the enable afterwards freezes the loop in place, and raising it again resumes from the same point. The punctual chip feeds the despreader. The lead/lag code and the timing offset show what the loop is doing.

The state machine has four states. `TS_IDLE` waits for the first enable. `TS_SEEK` steps the generator. `TS_TRACK` integrates and decides. `TS_HOLD` is the frozen state. The transitions are: load (IDLE to SEEK when enable is high), seek-done (SEEK to TRACK when the seek count reaches its last step), freeze (TRACK to HOLD when enable is low) and resume (HOLD to TRACK when enable is high).

Top module: `el_code_tracker`

## Requirements
- R1: The local code c[k] has period 31 chips (124 samples). Its first values are c[0]=1 and c[1..4]=0, and it follows c[k+5] = c[k] xor c[k+2]. Chip k covers samples 4k to 4k+3, and `punct_chip` equals c[phase div 4], where phase is the punctual sample index.
- R2: The first rising enable after reset loads `init_off` into both the phase and `tim_off`. A seek of (init_off div 4)+33 clocks follows. Strobes during the seek are ignored, and afterwards `punct_chip` equals c[init_off div 4].
- R3: The early replica is c[((phase+2) mod 124) div 4] and the late replica is c[((phase-2) mod 124) div 4].
- R4: Each processed strobe adds +1 to the window sum when only the early replica equals `smp_bit`, and -1 when only the late replica does. A window is 256 processed strobes.
- R5: At the window end, a sum above +2 sets `lead_lag` to 2'b10 (local lags) and raises `tim_off` by one. A sum below -2 sets 2'b01 (local leads) and lowers it by one. Otherwise `lead_lag` is 2'b00 and `tim_off` is unchanged. `lead_lag` holds until the next window end.
- R6: The phase advances one sample for each processed strobe. On the window-end strobe the advance is 2 samples after a lag decision and 0 after a lead decision.
- R7: The phase and `tim_off` wrap modulo 124 in both directions.
- R8: While enable is low, strobes are ignored and the phase, `tim_off`, `lead_lag` and the partial window sum are all kept. Tracking resumes one clock after enable returns high.
- R9: After reset, `tim_off` is 0, `lead_lag` is 2'b00 and `punct_chip` is 0.
- R10: With a starting error of at most two samples, `tim_off` equals the true received phase after three windows and stays there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_stb | input | 1 | One received sample is present this cycle |
| smp_bit | input | 1 | Hard-decision received sample |
| trk_en | input | 1 | Enable from acquisition; low freezes the loop |
| init_off | input | 7 | Coarse code phase in samples, below 124 |
| punct_chip | output | 1 | Punctual replica chip for despreading |
| lead_lag | output | 2 | Last decision: 00 balanced, 01 lead, 10 lag |
| tim_off | output | 7 | Current timing offset in samples |

## Verification
On every cycle the assertions check several properties. The offset and phase stay inside the code period. The offset moves only on a window-end strobe, and never after a balanced verdict. The held and seeking states leave the timing untouched. The lead/lag code is never both bits, the window sum never exceeds the count of samples taken, and the generator never reaches its all-zero lock-up state. Only the bench scenarios can show that the replica offsets, the sign of each decision, the wrap at the period edge and the pull-in from two samples either side converge onto the true received phase, and that a freeze in the middle of a window resumes without losing samples.

// File: rtl/el_trk_pkg.sv
package el_trk_pkg;

    typedef enum logic [1:0] {
        TS_IDLE  = 2'd0,
        TS_SEEK  = 2'd1,
        TS_TRACK = 2'd2,
        TS_HOLD  = 2'd3
    } trk_state_t;

    typedef enum logic [1:0] {
        LL_BAL  = 2'b00,
        LL_LEAD = 2'b01,
        LL_LAG  = 2'b10
    } ll_t;

endpackage

// File: rtl/el_pn_window.sv
module el_pn_window #(
    parameter int              DEG  = 5,
    parameter logic [DEG-1:0]  TAPS = 5'b00101,
    parameter logic [DEG-1:0]  SEED = 5'b00001
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic step,
    output logic chip_prev,
    output logic chip_cur,
    output logic chip_next
);

    logic [DEG-1:0] lfsr_q;
    logic [2:0]     win_q;
    logic           fb;

    assign fb = ^(lfsr_q & TAPS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lfsr_q <= SEED;
            win_q  <= '0;
        end else if (restart) begin
            lfsr_q <= SEED;
            win_q  <= '0;
        end else if (step) begin
            lfsr_q <= {fb, lfsr_q[DEG-1:1]};
            win_q  <= {win_q[1:0], lfsr_q[0]};
        end
    end

    assign chip_next = win_q[0];
    assign chip_cur  = win_q[1];
    assign chip_prev = win_q[2];

    AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_q != '0);  // R1

endmodule

// File: rtl/el_corr_window.sv
module el_corr_window
    import el_trk_pkg::*;
#(
    parameter int WIN_S = 256,
    parameter int DZ    = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic take,
    input  logic rx,
    input  logic early,
    input  logic late,
    output logic win_end,
    output ll_t  verdict
);

    localparam int CNT_W = $clog2(WIN_S);
    localparam int ACC_W = CNT_W + 2;
    localparam logic signed [ACC_W-1:0] DZ_HI = ACC_W'(DZ);
    localparam logic signed [ACC_W-1:0] DZ_LO = -DZ_HI;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W-1:0] inc;
    logic signed [ACC_W-1:0] total;
    logic        [CNT_W-1:0] cnt_q;
    logic        [ACC_W-1:0] acc_mag;

    always_comb begin
        inc = '0;
        if (early == rx && late != rx)
            inc = ACC_W'(1);
        else if (late == rx && early != rx)
            inc = {ACC_W{1'b1}};
    end

    assign total   = acc_q + inc;
    assign win_end = take && (cnt_q == CNT_W'(WIN_S - 1));

    always_comb begin
        if (total > DZ_HI)
            verdict = LL_LAG;
        else if (total < DZ_LO)
            verdict = LL_LEAD;
        else
            verdict = LL_BAL;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (clear) begin
            acc_q <= '0;
            cnt_q <= '0;
        end else if (take) begin
            if (win_end) begin
                acc_q <= '0;
                cnt_q <= '0;
            end else begin
                acc_q <= total;
                cnt_q <= cnt_q + CNT_W'(1);
            end
        end
    end

    assign acc_mag = acc_q[ACC_W-1] ? -acc_q : acc_q;

    AST_ACC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_mag <= {2'b00, cnt_q});  // R4

    AST_WIN_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        win_end |=> (cnt_q == '0));  // R4

endmodule

// File: rtl/el_code_tracker.sv
module el_code_tracker
    import el_trk_pkg::*;
#(
    parameter int              DEG       = 5,
    parameter logic [DEG-1:0]  TAPS      = 5'b00101,
    parameter logic [DEG-1:0]  SEED      = 5'b00001,
    parameter int              WIN_CHIPS = 64,
    parameter int              DZ        = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       smp_stb,
    input  logic       smp_bit,
    input  logic       trk_en,
    input  logic [6:0] init_off,
    output logic       punct_chip,
    output logic [1:0] lead_lag,
    output logic [6:0] tim_off
);

    localparam int P      = (1 << DEG) - 1;
    localparam int L      = 4 * P;
    localparam int OFF_W  = $clog2(L);
    localparam int SEEK_W = $clog2(2 * P + 2);
    localparam int WIN_S  = 4 * WIN_CHIPS;

    trk_state_t        st_q, st_d;
    logic [OFF_W-1:0]  phase_q, off_q;
    logic [SEEK_W-1:0] seek_q;
    ll_t               ll_q;

    logic       c_prev, c_cur, c_next;
    logic       e_rep, l_rep;
    logic       load, proc, pn_step;
    logic       win_end;
    ll_t        verdict;
    logic [1:0] sub, adv;
    logic [2:0] sum3;
    logic [OFF_W:0]   phase_sum;
    logic [OFF_W-1:0] phase_nx, off_up, off_dn;

    // Code generator with a three-chip view around the punctual chip
    el_pn_window #(.DEG(DEG), .TAPS(TAPS), .SEED(SEED)) u_pn (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (load),
        .step      (pn_step),
        .chip_prev (c_prev),
        .chip_cur  (c_cur),
        .chip_next (c_next)
    );

    // Replicas two samples either side of the punctual sample
    assign sub   = phase_q[1:0];
    assign e_rep = sub[1] ? c_next : c_cur;
    assign l_rep = sub[1] ? c_cur  : c_prev;

    assign load = (st_q == TS_IDLE) && trk_en;
    assign proc = (st_q == TS_TRACK) && trk_en && smp_stb;

    el_corr_window #(.WIN_S(WIN_S), .DZ(DZ)) u_corr (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (load),
        .take    (proc),
        .rx      (smp_bit),
        .early   (e_rep),
        .late    (l_rep),
        .win_end (win_end),
        .verdict (verdict)
    );

    // Sample advance for this strobe: 1 normally, 0 or 2 on a decision
    always_comb begin
        adv = 2'd1;
        if (win_end) begin
            unique case (verdict)
                LL_LAG:  adv = 2'd2;
                LL_LEAD: adv = 2'd0;
                default: adv = 2'd1;
            endcase
        end
    end

    assign sum3      = {1'b0, sub} + {1'b0, adv};
    assign pn_step   = (st_q == TS_SEEK) || (proc && sum3[2]);
    assign phase_sum = {1'b0, phase_q} + (OFF_W + 1)'(adv);
    assign phase_nx  = (phase_sum >= (OFF_W + 1)'(L))
                       ? OFF_W'(phase_sum - (OFF_W + 1)'(L))
                       : OFF_W'(phase_sum);
    assign off_up    = (off_q == OFF_W'(L - 1)) ? '0 : off_q + OFF_W'(1);
    assign off_dn    = (off_q == '0) ? OFF_W'(L - 1) : off_q - OFF_W'(1);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= TS_IDLE;
        else
            st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_IDLE:  if (trk_en)               st_d = TS_SEEK;
            TS_SEEK:  if (seek_q == SEEK_W'(1)) st_d = TS_TRACK;
            TS_TRACK: if (!trk_en)              st_d = TS_HOLD;
            TS_HOLD:  if (trk_en)               st_d = TS_TRACK;
        endcase
    end

    // Output and timing registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            off_q   <= '0;
            seek_q  <= '0;
            ll_q    <= LL_BAL;
        end else if (load) begin
            phase_q <= init_off[OFF_W-1:0];
            off_q   <= init_off[OFF_W-1:0];
            seek_q  <= SEEK_W'(init_off >> 2) + SEEK_W'(P + 2);
            ll_q    <= LL_BAL;
        end else if (st_q == TS_SEEK) begin
            seek_q <= seek_q - SEEK_W'(1);
        end else if (proc) begin
            phase_q <= phase_nx;
            if (win_end) begin
                ll_q <= verdict;
                if (verdict == LL_LAG)
                    off_q <= off_up;
                else if (verdict == LL_LEAD)
                    off_q <= off_dn;
            end
        end
    end

    assign punct_chip = c_cur;
    assign lead_lag   = ll_q;
    assign tim_off    = off_q;

    AST_OFF_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (off_q < OFF_W'(L)) && (phase_q < OFF_W'(L)));  // R7

    AST_HOLD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_HOLD) |=> ($stable(off_q) && $stable(phase_q) && $stable(ll_q)));  // R8

    AST_SEEK_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == TS_SEEK) |=> $stable(phase_q));  // R2

    AST_OFF_WINDOW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != TS_IDLE && !win_end) |=> $stable(off_q));  // R5

    AST_BAL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (win_end && verdict == LL_BAL) |=> $stable(off_q));  // R5

    AST_LL_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ll_q));  // R5

endmodule

// File: tb/el_code_tracker_test.sv
module el_code_tracker_test;

    localparam int P   = 31;
    localparam int L   = 124;
    localparam int WIN = 256;

    logic       clk = 1'b0;
    logic       rst_n, smp_stb, smp_bit, trk_en;
    logic [6:0] init_off;
    logic       punct_chip;
    logic [1:0] lead_lag;
    logic [6:0] tim_off;

    always #10 clk = ~clk;

    el_code_tracker uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_stb    (smp_stb),
        .smp_bit    (smp_bit),
        .trk_en     (trk_en),
        .init_off   (init_off),
        .punct_chip (punct_chip),
        .lead_lag   (lead_lag),
        .tim_off    (tim_off)
    );

    int checks = 0;
    int errors = 0;
    bit code [0:P-1];
    int mp, moff, mdiff, mcnt, n, d;
    int mll;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic bit chip_at(input int s);
        return code[((s % L) + L) % L / 4];
    endfunction

    task automatic start(input int init, input int dd);
        rst_n = 1'b0; trk_en = 1'b0; smp_stb = 1'b0; smp_bit = 1'b0;
        init_off = 7'(init);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tim_off == 0, "R9 reset offset", tim_off, 0);
        chk(lead_lag == 0, "R9 reset lead_lag", lead_lag, 0);
        chk(punct_chip == 0, "R9 reset punctual", punct_chip, 0);
        trk_en = 1'b1;
        repeat (20) @(negedge clk);
        smp_stb = 1'b1;             // strobes during the seek are ignored
        repeat (10) @(negedge clk);
        smp_stb = 1'b0;
        repeat (70) @(negedge clk);
        mp = init; moff = init; mll = 0; mdiff = 0; mcnt = 0; n = 0; d = dd;
        chk(tim_off == 7'(init), "R2 loaded offset", tim_off, init);
        chk(punct_chip == chip_at(init), "R2 punctual after seek", punct_chip, chip_at(init));
    endtask

    task automatic strobe();
        bit r, e, l;
        int adj;
        chk(punct_chip == chip_at(mp), "R1 punctual chip", punct_chip, chip_at(mp));
        r = chip_at(n + d);
        smp_stb = 1'b1;
        smp_bit = r;
        @(negedge clk);
        smp_stb = 1'b0;
        if (trk_en) begin
            e = chip_at(mp + 2);
            l = chip_at(mp - 2);
            if (e == r) mdiff++;
            if (l == r) mdiff--;
            mcnt++;
            adj = 0;
            if (mcnt == WIN) begin
                if (mdiff > 2) begin
                    adj = 1; mll = 2; moff = (moff + 1) % L;
                end else if (mdiff < -2) begin
                    adj = -1; mll = 1; moff = (moff + L - 1) % L;
                end else begin
                    mll = 0;
                end
                mdiff = 0;
                mcnt = 0;
            end
            mp = (mp + 1 + adj) % L;
            n++;
        end
        chk(tim_off == 7'(moff), "R3 R6 R7 timing offset", tim_off, moff);
        chk(lead_lag == 2'(mll), "R4 R5 lead_lag", lead_lag, mll);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // Local code from the recurrence of R1
        code[0] = 1'b1;
        for (int k = 1; k < 5; k++) code[k] = 1'b0;
        for (int k = 5; k < P; k++) code[k] = code[k-5] ^ code[k-3];

        // Pull-in from every starting error up to two samples: R10
        for (int err = -2; err <= 2; err++) begin
            start(40 + err, 40);
            for (int s = 0; s < 3 * WIN; s++) strobe();
            chk(tim_off == 7'd40, "R10 converged offset", tim_off, 40);
        end

        // Second received phase with a one-sample error: R10
        start(78, 77);
        for (int s = 0; s < 3 * WIN; s++) strobe();
        chk(tim_off == 7'd77, "R10 converged offset", tim_off, 77);

        // Upward wrap of the offset: R7
        start(L - 1, 0);
        for (int s = 0; s < 2 * WIN; s++) strobe();
        chk(tim_off == 7'd0, "R7 upward wrap", tim_off, 0);

        // Downward wrap of the offset: R7
        start(0, L - 1);
        for (int s = 0; s < 2 * WIN; s++) strobe();
        chk(tim_off == 7'(L - 1), "R7 downward wrap", tim_off, L - 1);

        // Freeze in the middle of a window, then resume: R8
        start(42, 40);
        for (int s = 0; s < 100; s++) strobe();
        trk_en = 1'b0;
        for (int s = 0; s < 60; s++) strobe();
        chk(tim_off == 7'(moff), "R8 frozen offset", tim_off, moff);
        trk_en = 1'b1;
        repeat (2) @(negedge clk);
        for (int s = 100; s < 3 * WIN; s++) strobe();
        chk(tim_off == 7'd40, "R8 R10 resumed convergence", tim_off, 40);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule